// File: doc/BRIEF.md
# Clock-Enable Generator with Per-Module Enable Buffering

This block lets a design that works at several rates run entirely on one fast clock. It does not divide the clock in logic to make a slower clock. A free-running modulo-`DIV_N` counter produces a single-cycle enable pulse once every `DIV_N` base-clock cycles. That pulse fans out to a set of consumer modules.

Each consumer takes the pulse through one local flip-flop before it uses it. The global enable net therefore carries only one load per module, and each local copy drives only the loads inside its own module. Every consumer uses the same one-flop delay, so all of them act on the same base-clock cycle. Which phase of the divider carries the pulse does not matter, as long as it is the same everywhere.

Inside each consumer, an enable-gated payload counter stands in for the real loads. It is clocked by the base clock and advances only on enabled cycles. Both the enable and its local copies are used only as data enables and never as clocks.

Top module: `ce_fabric`

## Requirements
- R1: The divider counts 0, 1, …, `DIV_N`-1 and wraps to 0. `ce_global_o` is high only on the cycle in which the counter has just wrapped to 0. With `rst_ni` released before rising edge 1, this is the state after rising edges `DIV_N`, 2·`DIV_N`, 3·`DIV_N`, ….
- R2: `ce_global_o` is a single-cycle pulse. It is never high on two consecutive cycles, and consecutive pulses are exactly `DIV_N` cycles apart.
- R3: Each bit i of `ce_local_o` is the value `ce_global_o` had one base-clock cycle earlier.
- R4: All bits of `ce_local_o` are always equal: every consumer sees its enable on the same cycle.
- R5: Each payload counter is a `PAY_W`-bit field. The field for consumer i sits at bits [i·`PAY_W` +: `PAY_W`] of `payload_o`. The counter increments by one (modulo 2^`PAY_W`) at a rising edge where its local enable is high. At every other edge it holds its value.
- R6: All payload fields are always equal.
- R7: While `rst_ni` is low, the counter, `ce_global_o`, every bit of `ce_local_o` and every payload field are 0. The reset is asynchronous.
- R8: After reset is released again in the middle of a run, the phase restarts from the beginning. The first global pulse comes after `DIV_N` edges, the local pulse one cycle later, and the first payload increment at edge `DIV_N`+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock for divider and all consumers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_global_o | output | 1 | Global enable pulse from the divider |
| ce_local_o | output | NUM_CONS | Locally re-registered enable of each consumer |
| payload_o | output | NUM_CONS*PAY_W | Payload counters, consumer i at bits [i*PAY_W +: PAY_W] |

## Verification
The bench runs long enough for the payload counters to wrap past 2^`PAY_W`. This shows the difference between a correct modulo increment and a counter that stalls or overflows at the top. A reset at power-up is followed by a second reset in the middle of the run, asserted at an arbitrary phase of the divider. This shows whether the phase truly restarts, rather than carrying on from where it was. Every cycle, a behavioural model based on edge counts is compared with the global pulse, with each local enable and with each payload field. A wrong pulse position, a missing or doubled local delay, or one consumer out of step with the others would each cause a mismatch.

// File: rtl/ce_pkg.sv
package ce_pkg;
  typedef enum logic [0:0] {
    CE_IDLE = 1'b0,
    CE_FIRE = 1'b1
  } ce_state_e;
endpackage

// File: rtl/ce_divider.sv
module ce_divider #(
  parameter int DIV_N = 4,
  localparam int CNT_W = (DIV_N > 2) ? $clog2(DIV_N) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ce_o
);
  import ce_pkg::*;

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_N - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;
  ce_state_e        ce_q;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ce_q  <= CE_IDLE;
    end else begin
      cnt_q <= at_last ? '0 : cnt_q + 1'b1;
      // pulse coincides with the wrap to zero
      ce_q  <= at_last ? CE_FIRE : CE_IDLE;
    end
  end

  assign ce_o = (ce_q == CE_FIRE);
endmodule

// File: rtl/ce_local_buf.sv
module ce_local_buf (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_i,
  output logic ce_o
);
  logic ce_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ce_q <= 1'b0;
    else         ce_q <= ce_i;
  end

  assign ce_o = ce_q;
endmodule

// File: rtl/ce_payload.sv
module ce_payload #(
  parameter int PAY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [PAY_W-1:0] val_o
);
  logic [PAY_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_q <= '0;
    else if (en_i) val_q <= val_q + 1'b1;
  end

  assign val_o = val_q;
endmodule

// File: rtl/ce_fabric.sv
module ce_fabric #(
  parameter int DIV_N    = 4,
  parameter int NUM_CONS = 4,
  parameter int PAY_W    = 8,
  localparam int BUS_W   = NUM_CONS * PAY_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                ce_global_o,
  output logic [NUM_CONS-1:0] ce_local_o,
  output logic [BUS_W-1:0]    payload_o
);
  logic ce_global;

  ce_divider #(.DIV_N(DIV_N)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_o  (ce_global)
  );

  // one flop per consumer: global net has one load per module
  for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
    logic             ce_loc;
    logic [PAY_W-1:0] val;

    ce_local_buf u_buf (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .ce_i  (ce_global),
      .ce_o  (ce_loc)
    );

    ce_payload #(.PAY_W(PAY_W)) u_pay (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ce_loc),
      .val_o (val)
    );

    assign ce_local_o[i]                = ce_loc;
    assign payload_o[i*PAY_W +: PAY_W]  = val;
  end

  assign ce_global_o = ce_global;
endmodule

// File: rtl/ce_fabric_chk.sv
module ce_fabric_chk #(
  parameter int DIV_N    = 4,
  parameter int NUM_CONS = 4,
  parameter int PAY_W    = 8,
  localparam int BUS_W   = NUM_CONS * PAY_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ce_global_o,
  input logic [NUM_CONS-1:0] ce_local_o,
  input logic [BUS_W-1:0]    payload_o
);
  int unsigned gap_q;
  logic        seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= 0;
      seen_q <= 1'b0;
    end else if (ce_global_o) begin
      gap_q  <= 0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  // R2: pulse spacing
  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_global_o && seen_q) |-> (gap_q == DIV_N - 1));

  a_r2_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_global_o |=> !ce_global_o);

  a_r3_follow_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_global_o |=> (&ce_local_o));

  a_r3_follow_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_global_o |=> (ce_local_o == '0));

  a_r4_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_local_o == '0) || (&ce_local_o));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_local_o[0] |=> $stable(payload_o));

  for (genvar i = 1; i < NUM_CONS; i++) begin : g_eq
    a_r6_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
      payload_o[i*PAY_W +: PAY_W] == payload_o[PAY_W-1:0]);
  end
endmodule

bind ce_fabric ce_fabric_chk #(
  .DIV_N(DIV_N), .NUM_CONS(NUM_CONS), .PAY_W(PAY_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_global_o(ce_global_o),
  .ce_local_o (ce_local_o),
  .payload_o  (payload_o)
);

// File: tb/ce_fabric_test.sv
`timescale 1ns/1ps
module ce_fabric_test;
  localparam int DIV_N    = 4;
  localparam int NUM_CONS = 4;
  localparam int PAY_W    = 8;
  localparam int MODV     = 1 << PAY_W;

  logic                      clk_i = 1'b0;
  logic                      rst_ni = 1'b0;
  logic                      ce_global_o;
  logic [NUM_CONS-1:0]       ce_local_o;
  logic [NUM_CONS*PAY_W-1:0] payload_o;

  int compared = 0;
  int mismatched = 0;
  int k = 0;
  int pay = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ce_fabric #(.DIV_N(DIV_N), .NUM_CONS(NUM_CONS), .PAY_W(PAY_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ce_global_o(ce_global_o),
    .ce_local_o(ce_local_o), .payload_o(payload_o)
  );

  function automatic bit exp_g(int n);
    return (n >= DIV_N) && (n % DIV_N == 0);
  endfunction
  function automatic bit exp_l(int n);
    return (n >= DIV_N + 1) && ((n - 1) % DIV_N == 0);
  endfunction

  // reference model: edge count since reset release
  always @(negedge rst_ni) begin k = 0; pay = 0; end
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      k = 0; pay = 0;
    end else begin
      if (exp_l(k)) pay = (pay + 1) % MODV;
      k = k + 1;
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      // R1 R7 R8
      compared++;
      if (ce_global_o !== exp_g(k)) begin
        mismatched++;
        $display("FAIL R1 global k=%0d act=%b exp=%b", k, ce_global_o, exp_g(k));
      end
      for (int i = 0; i < NUM_CONS; i++) begin
        // R3 R4
        compared++;
        if (ce_local_o[i] !== exp_l(k)) begin
          mismatched++;
          $display("FAIL R3 local[%0d] k=%0d act=%b exp=%b", i, k, ce_local_o[i], exp_l(k));
        end
        // R5 R6
        compared++;
        if (payload_o[i*PAY_W +: PAY_W] !== PAY_W'(pay)) begin
          mismatched++;
          $display("FAIL R5 payload[%0d] k=%0d act=%0d exp=%0d", i, k,
                   payload_o[i*PAY_W +: PAY_W], pay);
        end
      end
    end
  end

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(posedge clk_i);
  endtask

  initial begin
    rst_ni = 1'b0;
    run(3);
    #2 rst_ni = 1'b1;
    run(1100);          // R5 payload wraps past 2^PAY_W
    #2 rst_ni = 1'b0;   // R8 mid-run reset at arbitrary phase
    run(2);
    #2 rst_ni = 1'b1;
    run(41);
    #2 rst_ni = 1'b0;   // R7
    run(3);
    #2 rst_ni = 1'b1;
    run(20);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk_i);
    done = 1;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule